// File: doc/BRIEF.md
# Credit-Based Packet Offload Selector

This block is one node of a daisy-chained packet ring. Packet descriptors arrive from the upstream link, each one a flag marking it as raw or already processed plus a length in bytes. Per packet, the node decides whether to hand the packet to a locally attached compute unit or to pass it downstream. A raw packet is handed to the compute unit only while a credit counter permits it. The compute unit later hands back a processed packet, which joins the downstream stream.

All movements between the node's buffers share one local transfer medium. The medium is busy for a time proportional to the packet length. When it is idle, a processed packet returned by the compute unit takes it ahead of the head of the chain input queue. A transfer that has started always finishes. A packet that arrives while the input queue is full is discarded and counted.

Top module: `ofs_selector`

## Requirements
- R1: The chain input queue holds `IN_DEPTH` (default 10) packets. A packet presented on `in_valid_i` while the queue already holds that many, counting only packets the medium has not yet taken, is discarded.
- R2: `drop_count_o` resets to 0 and rises by exactly one for each discarded packet. Accepted packets leave it unchanged.
- R3: When the medium is idle and the head of the input queue is raw (`proc` = 0) with credit above zero, the packet is moved to the compute request buffer and appears on `req_len_o` with its length unchanged. Starting the move takes one credit.
- R4: A raw head packet met with zero credit goes to the chain output with `out_proc_o` = 0 and its length unchanged.
- R5: A processed head packet (`proc` = 1) from the chain goes to the chain output with `out_proc_o` = 1.
- R6: When the medium becomes idle with both a returned packet and an input-queue head waiting, the returned packet is moved first. It appears on the chain output with `out_proc_o` = 1 and its returned length.
- R7: A transfer holds the medium for max(1, length × `CYC_PER_BYTE`) cycles and is never pre-empted. A packet accepted into an idle node appears on `out_valid_o` that many cycles plus one after the accepting clock edge.
- R8: The credit starts at `INIT_CREDIT` (default 1). It rises by one when a returned packet has been written into the chain output queue, and it never exceeds `INIT_CREDIT`.
- R9: The chain output queue holds `OUT_DEPTH` (default 10) packets. It presents its head whenever it is non-empty, pops on `out_ready_i`, and keeps arrival order.
- R10: The return buffer and the request buffer each hold one packet. `ret_ready_o` is low while a returned packet waits for the medium.
- R11: After reset, `out_valid_o` and `req_valid_o` are 0, `ret_ready_o` is 1 and `drop_count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Packet present from the upstream link |
| in_proc_i | input | 1 | 1 = processed, 0 = raw |
| in_len_i | input | 11 | Packet length in bytes |
| out_ready_i | input | 1 | Downstream line idle |
| out_valid_o | output | 1 | Chain output queue non-empty |
| out_proc_o | output | 1 | Processed flag of the output head |
| out_len_o | output | 11 | Length of the output head |
| req_ready_i | input | 1 | Compute unit accepts a request |
| req_valid_o | output | 1 | Raw packet waiting for the compute unit |
| req_len_o | output | 11 | Length of the request packet |
| ret_valid_i | input | 1 | Compute unit returns a processed packet |
| ret_ready_o | output | 1 | Return buffer empty |
| ret_len_i | input | 11 | Length of the returned packet |
| drop_count_o | output | 16 | Number of discarded packets |

## Verification
The embedded assertions check on every cycle that:
- the drop counter moves only on an arrival at a full input queue;
- no queue is pushed when full or popped when empty;
- a transfer in progress keeps its destination and packet until it ends;
- an offload never starts with zero credit;
- the credit never exceeds its initial value;
- the input queue is never served while a returned packet could go.

Only the bench scenarios show the behaviours that depend on history:
- the routing decisions as the credit runs down and is restored;
- credit saturation after an unsolicited return;
- the exact transfer latency;
- the count of discarded packets under a burst;
- the order in which a returned packet overtakes the input queue without cutting a running transfer short.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int unsigned LEN_W = 11;

  typedef struct packed {
    logic             proc;
    logic [LEN_W-1:0] len;
  } pkt_t;

  typedef enum logic [1:0] {
    DST_NONE  = 2'd0,
    DST_CHAIN = 2'd1,
    DST_CMP   = 2'd2,
    DST_RET   = 2'd3
  } dst_e;
endpackage

// File: rtl/ofs_fifo.sv
module ofs_fifo #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ofs_credit.sv
module ofs_credit #(
  parameter int unsigned INIT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic give_i,
  output logic avail_o
);
  localparam int unsigned CW = $clog2(INIT + 1);

  logic [CW-1:0] credit_q;

  assign avail_o = (credit_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= CW'(INIT);
    end else if (take_i && !give_i) begin
      if (credit_q != '0) credit_q <= credit_q - CW'(1);
    end else if (give_i && !take_i) begin
      if (credit_q != CW'(INIT)) credit_q <= credit_q + CW'(1);
    end
  end

  a_r8_credit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_q <= CW'(INIT));
  a_r3_take_needs_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> credit_q != '0);
endmodule

// File: rtl/ofs_medium.sv
module ofs_medium
  import ofs_pkg::*;
#(
  parameter int unsigned CPB = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_avail_i,
  input  pkt_t             in_head_i,
  input  logic             ret_avail_i,
  input  logic [LEN_W-1:0] ret_len_i,
  input  logic             out_space_i,
  input  logic             cmp_space_i,
  input  logic             credit_avail_i,
  output logic             in_pop_o,
  output logic             ret_pop_o,
  output logic             take_credit_o,
  output logic             give_credit_o,
  output logic             out_push_o,
  output pkt_t             out_pkt_o,
  output logic             cmp_push_o,
  output logic [LEN_W-1:0] cmp_len_o
);
  localparam int unsigned DUR_W = LEN_W + $clog2(CPB + 1);

  dst_e             dst_q, sel;
  pkt_t             pkt_q, sel_pkt;
  logic [DUR_W-1:0] cnt_q, dur;
  logic             idle, last;

  assign idle = (dst_q == DST_NONE);
  assign last = !idle && (cnt_q == '0);

  always_comb begin
    sel     = DST_NONE;
    sel_pkt = in_head_i;
    if (idle) begin
      if (ret_avail_i && out_space_i) begin
        sel     = DST_RET;
        sel_pkt = '{proc: 1'b1, len: ret_len_i};
      end else if (in_avail_i) begin
        if (in_head_i.proc) begin
          if (out_space_i) sel = DST_CHAIN;
        end else if (credit_avail_i) begin
          if (cmp_space_i) sel = DST_CMP;
        end else if (out_space_i) begin
          sel = DST_CHAIN;
        end
      end
    end
  end

  always_comb begin
    dur = DUR_W'(sel_pkt.len) * DUR_W'(CPB);
    if (dur == '0) dur = DUR_W'(1);
  end

  assign in_pop_o      = (sel == DST_CHAIN) || (sel == DST_CMP);
  assign ret_pop_o     = (sel == DST_RET);
  assign take_credit_o = (sel == DST_CMP);
  assign out_push_o    = last && ((dst_q == DST_CHAIN) || (dst_q == DST_RET));
  assign give_credit_o = last && (dst_q == DST_RET);
  assign cmp_push_o    = last && (dst_q == DST_CMP);
  assign out_pkt_o     = pkt_q;
  assign cmp_len_o     = pkt_q.len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q <= DST_NONE;
      pkt_q <= '0;
      cnt_q <= '0;
    end else if (idle) begin
      if (sel != DST_NONE) begin
        dst_q <= sel;
        pkt_q <= sel_pkt;
        cnt_q <= dur - DUR_W'(1);
      end
    end else if (last) begin
      dst_q <= DST_NONE;
    end else begin
      cnt_q <= cnt_q - DUR_W'(1);
    end
  end

  a_r7_no_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !last) |=> (dst_q == $past(dst_q)) && $stable(pkt_q));
  a_r6_ret_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pop_o |-> !(ret_avail_i && out_space_i));
endmodule

// File: rtl/ofs_selector.sv
module ofs_selector
  import ofs_pkg::*;
#(
  parameter int unsigned IN_DEPTH     = 10,
  parameter int unsigned OUT_DEPTH    = 10,
  parameter int unsigned CMP_DEPTH    = 1,
  parameter int unsigned INIT_CREDIT  = 1,
  parameter int unsigned CYC_PER_BYTE = 1,
  parameter int unsigned DROP_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_proc_i,
  input  logic [LEN_W-1:0]  in_len_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic              out_proc_o,
  output logic [LEN_W-1:0]  out_len_o,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [LEN_W-1:0]  req_len_o,
  input  logic              ret_valid_i,
  output logic              ret_ready_o,
  input  logic [LEN_W-1:0]  ret_len_i,
  output logic [DROP_W-1:0] drop_count_o
);
  localparam int unsigned PKT_W = $bits(pkt_t);

  pkt_t             in_head, out_push_pkt, out_head;
  logic             in_empty, in_full, in_pop, in_push;
  logic             out_empty, out_full, out_push, out_pop;
  logic             req_empty, req_full, req_push, req_pop;
  logic             ret_empty, ret_full, ret_push, ret_pop;
  logic [LEN_W-1:0] cmp_len, ret_head;
  logic             credit_avail, take_credit, give_credit;
  logic [DROP_W-1:0] drop_q;

  assign in_push = in_valid_i && !in_full;

  ofs_fifo #(.DEPTH(IN_DEPTH), .WIDTH(PKT_W)) i_in_q (
    .clk_i, .rst_ni, .push_i(in_push), .din_i({in_proc_i, in_len_i}),
    .pop_i(in_pop), .dout_o(in_head), .empty_o(in_empty), .full_o(in_full));

  ofs_fifo #(.DEPTH(OUT_DEPTH), .WIDTH(PKT_W)) i_out_q (
    .clk_i, .rst_ni, .push_i(out_push), .din_i(out_push_pkt),
    .pop_i(out_pop), .dout_o(out_head), .empty_o(out_empty), .full_o(out_full));

  ofs_fifo #(.DEPTH(CMP_DEPTH), .WIDTH(LEN_W)) i_req_buf (
    .clk_i, .rst_ni, .push_i(req_push), .din_i(cmp_len),
    .pop_i(req_pop), .dout_o(req_len_o), .empty_o(req_empty), .full_o(req_full));

  ofs_fifo #(.DEPTH(CMP_DEPTH), .WIDTH(LEN_W)) i_ret_buf (
    .clk_i, .rst_ni, .push_i(ret_push), .din_i(ret_len_i),
    .pop_i(ret_pop), .dout_o(ret_head), .empty_o(ret_empty), .full_o(ret_full));

  ofs_credit #(.INIT(INIT_CREDIT)) i_credit (
    .clk_i, .rst_ni, .take_i(take_credit), .give_i(give_credit),
    .avail_o(credit_avail));

  ofs_medium #(.CPB(CYC_PER_BYTE)) i_medium (
    .clk_i, .rst_ni,
    .in_avail_i(!in_empty), .in_head_i(in_head),
    .ret_avail_i(!ret_empty), .ret_len_i(ret_head),
    .out_space_i(!out_full), .cmp_space_i(!req_full),
    .credit_avail_i(credit_avail),
    .in_pop_o(in_pop), .ret_pop_o(ret_pop),
    .take_credit_o(take_credit), .give_credit_o(give_credit),
    .out_push_o(out_push), .out_pkt_o(out_push_pkt),
    .cmp_push_o(req_push), .cmp_len_o(cmp_len));

  assign out_valid_o = !out_empty;
  assign out_proc_o  = out_head.proc;
  assign out_len_o   = out_head.len;
  assign out_pop     = out_valid_o && out_ready_i;

  assign req_valid_o = !req_empty;
  assign req_pop     = req_valid_o && req_ready_i;

  assign ret_ready_o = !ret_full;
  assign ret_push    = ret_valid_i && ret_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  drop_q <= '0;
    else if (in_valid_i && in_full) drop_q <= drop_q + DROP_W'(1);
  end
  assign drop_count_o = drop_q;

  a_r2_drop_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_full) |=> drop_count_o == $past(drop_count_o) + DROP_W'(1));
  a_r1_accept_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_full) |=> $stable(drop_count_o));
  a_r10_ret_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_push && !ret_pop) |=> !ret_ready_o);
endmodule

// File: tb/test_ofs_selector.sv
`timescale 1ns/1ps
module test_ofs_selector;
  import ofs_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_proc_i = 1'b0, out_ready_i = 1'b1;
  logic req_ready_i = 1'b1, ret_valid_i = 1'b0;
  logic [LEN_W-1:0] in_len_i = '0, ret_len_i = '0;
  logic out_valid_o, out_proc_o, req_valid_o, ret_ready_o;
  logic [LEN_W-1:0] out_len_o, req_len_o;
  logic [15:0] drop_count_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ofs_selector i_ofs_selector (
    .clk_i(clk), .rst_ni, .in_valid_i, .in_proc_i, .in_len_i, .out_ready_i,
    .out_valid_o, .out_proc_o, .out_len_o, .req_ready_i, .req_valid_o, .req_len_o,
    .ret_valid_i, .ret_ready_o, .ret_len_i, .drop_count_o);

  // vector: {is_return, proc, exp_at_req, exp_proc, len[7:0]}
  localparam logic [11:0] VEC [9] = '{
    {4'b0010, 8'd3},  // R3 raw, credit 1 -> compute
    {4'b0000, 8'd4},  // R4 raw, credit 0 -> chain raw
    {4'b0101, 8'd5},  // R5 processed -> chain
    {4'b1001, 8'd6},  // R6 return -> chain processed, credit back
    {4'b0010, 8'd7},  // R8 credit restored -> compute
    {4'b1001, 8'd2},  // return
    {4'b1001, 8'd3},  // R8 unsolicited return, credit saturates
    {4'b0010, 8'd9},  // one credit only
    {4'b0000, 8'd1}   // R8 second raw -> chain
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_in(input logic proc, input int len);
    @(negedge clk);
    in_valid_i = 1'b1; in_proc_i = proc; in_len_i = LEN_W'(len);
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic push_ret(input int len);
    @(negedge clk);
    ret_valid_i = 1'b1; ret_len_i = LEN_W'(len);
    @(negedge clk);
    ret_valid_i = 1'b0;
  endtask

  // port: 0 chain out, 1 request, 2 none
  task automatic get_event(output int port, output int proc, output int len);
    port = 2; proc = 0; len = 0;
    for (int k = 0; k < 4000; k++) begin
      if (req_valid_o && req_ready_i) begin
        port = 1; len = int'(req_len_o); break;
      end
      if (out_valid_o && out_ready_i) begin
        port = 0; proc = int'(out_proc_o); len = int'(out_len_o); break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int port, proc, len, n;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(out_valid_o == 1'b0, "R11 out_valid", int'(out_valid_o), 0);
    check(req_valid_o == 1'b0, "R11 req_valid", int'(req_valid_o), 0);
    check(ret_ready_o == 1'b1, "R11 ret_ready", int'(ret_ready_o), 1);
    check(drop_count_o == 16'd0, "R11 drop_count", int'(drop_count_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < 9; i++) begin
      if (VEC[i][11]) push_ret(int'(VEC[i][7:0]));
      else            push_in(VEC[i][10], int'(VEC[i][7:0]));
      get_event(port, proc, len);
      check(port == int'(VEC[i][9]), "R3/R4/R5/R6/R8 route", port, int'(VEC[i][9]));
      if (!VEC[i][9])
        check(proc == int'(VEC[i][8]), "R4/R5/R6 proc flag", proc, int'(VEC[i][8]));
      check(len == int'(VEC[i][7:0]), "R3/R4/R5 length", len, int'(VEC[i][7:0]));
      repeat (3) @(negedge clk);
    end
    check(drop_count_o == 16'd0, "R2 no drops in table", int'(drop_count_o), 0);

    // R7 latency on idle node; credit is 0 here
    push_in(1'b1, 12);
    n = 0;
    while (!out_valid_o && n < 1000) begin @(negedge clk); n++; end
    check(n == 13, "R7 latency len 12", n, 13);
    repeat (2) @(negedge clk);
    push_in(1'b1, 0);
    n = 0;
    while (!out_valid_o && n < 1000) begin @(negedge clk); n++; end
    check(n == 2, "R7 latency len 0", n, 2);
    repeat (2) @(negedge clk);

    // R6/R7/R10: return arrives during a long transfer, raw waits behind it
    push_ret(4);                          // restore credit to 1
    get_event(port, proc, len);
    check(port == 0 && len == 4, "R6 restore return", len, 4);
    push_in(1'b1, 30);                    // long processed transfer
    repeat (3) @(negedge clk);
    fork
      push_ret(5);
      push_in(1'b0, 4);
    join
    check(ret_ready_o == 1'b0, "R10 ret_ready low while held", int'(ret_ready_o), 0);
    get_event(port, proc, len);
    check(port == 0 && len == 30, "R7 running transfer first", len, 30);
    get_event(port, proc, len);
    check(port == 0 && len == 5 && proc == 1, "R6 return before raw", len, 5);
    get_event(port, proc, len);
    check(port == 1 && len == 4, "R8 credit back, raw offloaded", port, 1);
    repeat (3) @(negedge clk);

    // R1/R2/R9 overflow burst with blocked output
    out_ready_i = 1'b0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      in_valid_i = 1'b1; in_proc_i = 1'b1; in_len_i = LEN_W'(200 + i);
    end
    @(negedge clk);
    in_valid_i = 1'b0;
    check(drop_count_o == 16'd14, "R1/R2 drops on full input", int'(drop_count_o), 14);
    out_ready_i = 1'b1;
    for (int i = 0; i < 11; i++) begin
      get_event(port, proc, len);
      check(port == 0 && len == 200 + i, "R9 output order", len, 200 + i);
    end
    repeat (3) @(negedge clk);
    check(out_valid_o == 1'b0, "R9 output drained", int'(out_valid_o), 0);
    check(drop_count_o == 16'd14, "R2 drop count stable", int'(drop_count_o), 14);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule